// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a byte-wide host bus access to a bank of peripheral registers through only two host-visible registers. The control register carries a six-bit target address, an auto-read enable and a BUSY flag. The data register carries the byte being moved. When the host writes the data register, the bridge writes that byte to the addressed target register. When the host sets BUSY, the bridge reads the target register, and the host collects the byte from the data register once BUSY has cleared. With auto-read enabled, each host read of the data register starts the next read of the same address. This lets a host stream a FIFO window without rewriting the control register.

Internally, the bridge talks to its target over a one-cycle request and acknowledge port with a parameterised latency. A target register file is built in so that the bridge can be exercised as a whole. It has twelve mapped byte registers in the low sixteen addresses and four small byte FIFOs behind addresses 0x20 to 0x23.

Top module: `ibr_bridge`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00 (idle, auto-read off, address 0) and the data register reads 0x00.
- R2: In the control register, bit 7 is BUSY, bit 6 is auto-read and bits 5:0 are the target address. A control write while idle stores bits 6:0, and a control read returns all three fields.
- R3: A data-register write while idle stores the byte and writes it to the target register at the held address. Consecutive data writes reuse that address without a control write in between.
- R4: A control write with bit 7 set starts a target read at the address given in the same write. BUSY returns to 0 once the byte has been captured, and the data register then returns it.
- R5: With auto-read set, a host read of the data register while idle returns the held byte and starts a new read of the same address, so BUSY reads 1 on the next cycle. With auto-read clear, the same host read starts nothing.
- R6: While BUSY is 1, host writes to either register are ignored: no second transfer starts, and the data byte and address are kept. Writing 0 to bit 7 never cancels a transfer.
- R7: Target addresses 0x00, 0x01, 0x02, 0x04, 0x06, 0x07, 0x09, 0x0B, 0x0C, 0x0D, 0x0E and 0x0F are read/write byte registers. Every other address below 0x20, and every address from 0x24 to 0x3F, reads 0x00 and discards writes.
- R8: Target addresses 0x20 to 0x23 are four independent FIFOs, each FIFO_DEPTH bytes deep (default 4). A write pushes a byte and a read pops the oldest byte. A read of an empty FIFO returns 0x00, and a write to a full FIFO is discarded.
- R9: Each transfer keeps BUSY at 1 for exactly ACC_LAT+2 cycles, counted from the edge that starts it (default ACC_LAT = 3, so 5 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read (only matters for auto-read) |
| host_sel | input | 1 | Register select: 0 = control, 1 = data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected host register, combinational |

## Verification
Every mapped and unmapped target address is tried with its own write-then-read pattern. This separates a correct address decode from one that aliases, drops or leaks bytes. The FIFO window is tried with three patterns: a partial fill, an over-fill past the depth, and a read of an untouched neighbour FIFO. Together these show ordering, the full-drop rule, the empty read of zero and FIFO independence. Writes issued during a transfer, including a BUSY write of 0, show that a busy bridge neither starts a second transfer nor cancels the first. A BUSY-width measurement and the auto-read on/off comparison pin down the transfer timing and the condition for re-arming a read.

// File: rtl/ibr_pkg.sv
// Shared constants for the indirect register access bridge.
// Assumes a byte-wide host bus and a 6-bit target address space.
package ibr_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 6;
    localparam int BUSY_BIT    = 7;
    localparam int AUTO_BIT    = 6;
    localparam logic SEL_CTL   = 1'b0;
    localparam logic SEL_DATA  = 1'b1;
    // One bit per low target address: 1 = mapped byte register.
    localparam logic [15:0] REG_MAP = 16'hFAD7;
    // Address bits 5:2 that select the FIFO window.
    localparam logic [3:0] FIFO_WIN = 4'b1000;
    localparam int N_FIFO      = 4;
endpackage

// File: rtl/ibr_test_fifo.sv
// Small byte FIFO used as a target test model.
// Push while full is dropped; head reads 0 when empty.
// Assumes push and pop never arrive in the same cycle.
module ibr_test_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    wire do_push = push && (cnt_q != CW'(DEPTH));
    wire do_pop  = pop && (cnt_q != '0);

    // Store pushed byte at write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head = (cnt_q == '0) ? '0 : mem[rp_q];

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R8
    AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH))); // R8
endmodule

// File: rtl/ibr_target_regs.sv
// Target side: accepts one-cycle requests, waits ACC_LAT cycles, then
// performs the access and pulses ack with read data for one cycle.
// Holds mapped byte registers and the FIFO window test model.
// Assumes no new request arrives while one is pending.
module ibr_target_regs
    import ibr_pkg::*;
#(
    parameter int ACC_LAT    = 3,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata
);
    localparam int LW = (ACC_LAT > 1) ? $clog2(ACC_LAT + 1) : 1;

    logic              pend_q;
    logic [LW-1:0]     cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] reg_rd   [16];
    logic [DATA_W-1:0] fifo_hd  [N_FIFO];

    wire fire   = pend_q && (cnt_q == '0);
    wire in_reg = (addr_q[5:4] == 2'b00);
    wire in_win = (addr_q[5:2] == FIFO_WIN);

    // Latch the request and count down the access latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (req) begin
            pend_q  <= 1'b1;
            cnt_q   <= LW'(ACC_LAT - 1);
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end else if (fire) begin
            pend_q  <= 1'b0;
        end else if (pend_q) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // One storage byte per mapped address; unmapped slots read zero.
    for (genvar i = 0; i < 16; i++) begin : g_reg
        if (REG_MAP[i]) begin : g_map
            logic [DATA_W-1:0] val_q;
            // Capture a write that targets this slot.
            always_ff @(posedge clk) begin
                if (!rst_n) val_q <= '0;
                else if (fire && we_q && in_reg && addr_q[3:0] == 4'(i))
                    val_q <= wdata_q;
            end
            assign reg_rd[i] = val_q;
        end else begin : g_hole
            assign reg_rd[i] = '0;
        end
    end

    // One test FIFO per window address.
    for (genvar f = 0; f < N_FIFO; f++) begin : g_fifo
        wire sel_f = fire && in_win && (addr_q[1:0] == 2'(f));
        ibr_test_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (sel_f && we_q),
            .pop   (sel_f && !we_q),
            .din   (wdata_q),
            .head  (fifo_hd[f])
        );
    end

    // Select read data by address region.
    always_comb begin
        rd_val = '0;
        if (in_reg)      rd_val = reg_rd[addr_q[3:0]];
        else if (in_win) rd_val = fifo_hd[addr_q[1:0]];
    end

    // Register acknowledge and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            ack_rdata <= '0;
        end else begin
            ack <= fire;
            if (fire && !we_q) ack_rdata <= rd_val;
        end
    end

    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> !pend_q); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R9
endmodule

// File: rtl/ibr_host_regs.sv
// Host-facing control and data registers plus transfer sequencing.
// Launches target writes on data writes and target reads on BUSY set
// or on an auto-read data read; drops host writes while busy.
// Assumes host_wr and host_rd are one-cycle strobes; write wins a tie.
module ibr_host_regs
    import ibr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              tgt_req,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_we,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_ack,
    input  logic [DATA_W-1:0] tgt_rdata
);
    logic              busy_q, auto_q, op_we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    wire idle       = !busy_q;
    wire wr_ctl     = host_wr && host_sel == SEL_CTL && idle;
    wire wr_dat     = host_wr && host_sel == SEL_DATA && idle;
    wire rd_auto    = host_rd && !host_wr && host_sel == SEL_DATA && idle && auto_q;
    wire launch_rd  = (wr_ctl && host_wdata[BUSY_BIT]) || rd_auto;
    wire launch     = launch_rd || wr_dat;

    // Update host registers, BUSY and the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            auto_q  <= 1'b0;
            op_we_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            tgt_req <= 1'b0;
        end else begin
            tgt_req <= launch;
            if (wr_ctl) begin
                addr_q <= host_wdata[ADDR_W-1:0];
                auto_q <= host_wdata[AUTO_BIT];
            end
            if (wr_dat) data_q <= host_wdata;
            if (launch) begin
                busy_q  <= 1'b1;
                op_we_q <= wr_dat;
            end else if (tgt_ack) begin
                busy_q  <= 1'b0;
                if (!op_we_q) data_q <= tgt_rdata;
            end
        end
    end

    assign tgt_addr  = addr_q;
    assign tgt_we    = op_we_q;
    assign tgt_wdata = data_q;

    // Return the selected host register.
    always_comb begin
        if (host_sel == SEL_CTL) host_rdata = {busy_q, auto_q, addr_q};
        else                     host_rdata = data_q;
    end

    AST_NO_SECOND_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tgt_ack) |=> !tgt_req); // R6
    AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !tgt_ack) |=> $stable(data_q)); // R6
    AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_ack |-> busy_q); // R9
    AST_ACK_FREES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_ack |=> !busy_q); // R4
    AST_REQ_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> busy_q); // R3
endmodule

// File: rtl/ibr_bridge.sv
// Top of the indirect register access bridge: host register front end
// joined to the latency-modelled target register bank.
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int ACC_LAT    = 3,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);
    logic              t_req, t_we, t_ack;
    logic [ADDR_W-1:0] t_addr;
    logic [DATA_W-1:0] t_wdata, t_rdata;

    ibr_host_regs u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tgt_req    (t_req),
        .tgt_addr   (t_addr),
        .tgt_we     (t_we),
        .tgt_wdata  (t_wdata),
        .tgt_ack    (t_ack),
        .tgt_rdata  (t_rdata)
    );

    ibr_target_regs #(.ACC_LAT(ACC_LAT), .FIFO_DEPTH(FIFO_DEPTH)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (t_req),
        .req_addr  (t_addr),
        .req_we    (t_we),
        .req_wdata (t_wdata),
        .ack       (t_ack),
        .ack_rdata (t_rdata)
    );
endmodule

// File: tb/sim_ibr_bridge.sv
module sim_ibr_bridge;
    localparam int LAT = 3;
    localparam logic CTL = 1'b0;
    localparam logic DAT = 1'b1;
    // {address, write byte, expected read-back}
    localparam logic [23:0] VEC [16] = '{
        24'h00_5A_5A, 24'h01_C3_C3, 24'h02_0F_0F, 24'h04_F0_F0,
        24'h06_3C_3C, 24'h07_81_81, 24'h09_7E_7E, 24'h0B_12_12,
        24'h0C_FF_FF, 24'h0D_01_01, 24'h0E_03_03, 24'h0F_80_80,
        24'h03_55_00, 24'h05_77_00, 24'h10_11_00, 24'h3F_AA_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    ibr_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] val);
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] val);
        host_sel = sel; host_rd = 1'b1;
        #1 val = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(output logic [7:0] val);
        host_sel = CTL;
        #1 val = host_rdata;
        @(negedge clk);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v;
        for (int n = 0; n < 200; n++) begin
            peek(v);
            if (!v[7]) return;
        end
        chk({tag, " busy timeout"}, 8'h80, 8'h00);
    endtask

    task automatic tgt_read(input logic [5:0] a, output logic [7:0] val);
        wr(CTL, {2'b10, a});
        wait_idle("read");
        rd(DAT, val);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(v); chk("R1 ctl", v, 8'h00);
        rd(DAT, v); chk("R1 data", v, 8'h00);

        // R2 field readback
        wr(CTL, 8'h6A); peek(v); chk("R2 ctl readback", v, 8'h6A);
        wr(CTL, 8'h00);

        // R7 address map walk (R3 write, R4 read)
        for (int i = 0; i < 16; i++) begin
            wr(CTL, {2'b00, VEC[i][21:16]});
            wr(DAT, VEC[i][15:8]);
            wait_idle("R3");
            tgt_read(VEC[i][21:16], v);
            chk($sformatf("R7 addr %02h", VEC[i][23:16]), v, VEC[i][7:0]);
        end

        // R9 busy width
        wr(CTL, 8'h01);
        wr(DAT, 8'h11);
        n = 0;
        for (int k = 0; k < 50; k++) begin
            peek(v);
            if (!v[7]) break;
            n++;
        end
        chk("R9 busy cycles", 8'(n), 8'(LAT + 2));

        // R6 writes while busy ignored, BUSY=0 write does not cancel
        wr(DAT, 8'h33);
        wr(DAT, 8'h22);
        wr(CTL, 8'h05);
        peek(v); chk("R6 busy kept, addr kept", v, 8'h81);
        wait_idle("R6");
        rd(DAT, v); chk("R6 data byte kept", v, 8'h33);
        tgt_read(6'h01, v); chk("R6 no second write", v, 8'h33);
        tgt_read(6'h05, v); chk("R6 dropped addr untouched", v, 8'h00);

        // R3 repeated data writes without address reload, then R5 off
        wr(CTL, 8'h0E);
        wr(DAT, 8'h44); wait_idle("R3");
        wr(DAT, 8'h45); wait_idle("R3");
        wr(CTL, 8'h8E); wait_idle("R4");
        rd(DAT, v); chk("R3 repeated write", v, 8'h45);
        peek(v); chk("R5 no auto launch", v, 8'h0E);

        // R8 FIFO order and empty read, R5 auto re-arm
        wr(CTL, 8'h20);
        wr(DAT, 8'hA1); wait_idle("R8");
        wr(DAT, 8'hA2); wait_idle("R8");
        wr(DAT, 8'hA3); wait_idle("R8");
        wr(CTL, 8'hE0); wait_idle("R5");
        rd(DAT, v); chk("R8 pop 1", v, 8'hA1);
        peek(v); chk("R5 auto re-armed", v, 8'hE0);
        wait_idle("R5");
        rd(DAT, v); chk("R8 pop 2", v, 8'hA2); wait_idle("R5");
        rd(DAT, v); chk("R8 pop 3", v, 8'hA3); wait_idle("R5");
        rd(DAT, v); chk("R8 empty read", v, 8'h00); wait_idle("R5");

        // R8 overfill drops fifth byte
        wr(CTL, 8'h21);
        for (int k = 0; k < 5; k++) begin
            wr(DAT, 8'hB0 + 8'(k)); wait_idle("R8");
        end
        wr(CTL, 8'hE1); wait_idle("R8");
        for (int k = 0; k < 5; k++) begin
            rd(DAT, v);
            chk($sformatf("R8 full fifo pop %0d", k), v, (k < 4) ? 8'hB0 + 8'(k) : 8'h00);
            wait_idle("R8");
        end
        wr(CTL, 8'h00);
        tgt_read(6'h22, v); chk("R8 neighbour fifo empty", v, 8'h00);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule